// File: doc/BRIEF.md
# Suspend and Wake Sequencer

This block controls the low-power suspend handshake. It watches an asynchronous suspend request. Before the sequencer sees the request, the request passes through a two-flop synchronizer and an optional level filter. When a suspend is recognised, the block drops its awake indication and raises three global controls in a fixed order. First it locks all writable clocked storage against writes. Next it forces outputs to their safe suspend state. Last it disables inputs and internal routing. A programmable number of clock cycles separates each step.

When the request is withdrawn, the block re-enables inputs at once. It then raises awake after a wake delay. After that it releases the write lock and the output hold independently, each after its own count of 1 or 512 cycles, chosen by two select inputs. If a new suspend request arrives while a wake is still in progress, the block abandons the wake, reasserts every protection in one cycle and returns to the suspended phase. A phase output reports where the sequencer stands.

Top module: `susp_wake_seq`

## Requirements
- R1: Out of reset the block is awake: `awake_o`=1, `wr_lock_o`=0, `out_hold_o`=0, `in_en_o`=1, and `phase_o`=2'b00. The phase codes are 00 awake, 01 entering, 10 suspended and 11 waking.
- R2: With the filter enabled, a level on `susp_req_i` reaches the sequencer only after the synchronized input has held that level for FILT_LEN consecutive cycles. With FILT_LEN=4, a high pulse of 3 cycles has no effect, and a pulse of 4 cycles starts a suspend.
- R3: If a high level on `susp_req_i` is first present at clock edge k, then `awake_o` falls and `wr_lock_o` rises at edge k+2+FILT_LEN when the filter is enabled, or at edge k+2 when it is disabled. `phase_o` becomes 01 at that edge.
- R4: During entry, `out_hold_o` rises STEP_GAP cycles after `wr_lock_o`. `in_en_o` falls STEP_GAP cycles after that, at the same edge where `phase_o` becomes 10. Entry runs to completion even if the request drops partway through.
- R5: From the suspended phase, a recognised low request raises `in_en_o` and sets `phase_o` to 11 in one cycle. `awake_o` rises WAKE_DLY cycles later.
- R6: After `awake_o` rises, `wr_lock_o` falls after 1 cycle when `lock_long_i`=0, or after 512 cycles when it is 1. The select is sampled when the wake begins.
- R7: After `awake_o` rises, `out_hold_o` falls after 1 or 512 cycles according to `hold_long_i`, independently of R6. `phase_o` returns to 00 at the edge where the later of the two releases happens.
- R8: A suspend recognised during the waking phase drives `awake_o`=0, `wr_lock_o`=1, `out_hold_o`=1 and `in_en_o`=0 together in one cycle, and `phase_o` becomes 10.
- R9: Inputs are never disabled while the lock or the hold is released. `awake_o` is never high while `in_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| susp_req_i | input | 1 | Asynchronous suspend request, active high |
| lock_long_i | input | 1 | Write-lock release count: 0 gives 1 cycle, 1 gives 512 cycles |
| hold_long_i | input | 1 | Output-hold release count: 0 gives 1 cycle, 1 gives 512 cycles |
| awake_o | output | 1 | High while the block is not suspended |
| wr_lock_o | output | 1 | Global write lock for clocked storage |
| out_hold_o | output | 1 | Forces outputs to their suspend state |
| in_en_o | output | 1 | Enables inputs and internal routing |
| phase_o | output | 2 | Sequencer phase code (see R1) |

## Verification
The write-lock release and the output-hold release each run on their own counter, so they can fall in the same cycle. The bench provokes this by sweeping all four combinations of the two select inputs. With equal selects, both releases and the return to phase 00 must land on one edge. With unequal selects, they must land exactly 511 cycles apart.

The second collision is a new suspend that arrives while a wake is still running. The bench raises the request after awake has risen but while both releases are still pending. It then checks that every protection is reasserted in a single cycle and that the pending releases never take effect.

// File: rtl/susp_pkg.sv
package susp_pkg;
    typedef enum logic [1:0] {
        PH_AWAKE = 2'b00,
        PH_ENTER = 2'b01,
        PH_SUSP  = 2'b10,
        PH_WAKE  = 2'b11
    } phase_t;
endpackage

// File: rtl/susp_in_cond.sv
// Request conditioning: two-flop synchronizer plus optional level filter.
module susp_in_cond #(
    parameter bit FILT_EN  = 1'b1,
    parameter int FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic lvl_o
);
    localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          lvl;
        logic [CW-1:0] cnt;
    } cond_t;

    cond_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = req_i;
        st_d.s2 = st_q.s1;
        if (st_q.s2 != st_q.lvl) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.lvl = st_q.s2;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (FILT_EN) begin : g_filt
            assign lvl_o = st_q.lvl;
        end else begin : g_raw
            assign lvl_o = st_q.s2;
        end
    endgenerate

    // R2
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl != $past(st_q.lvl)) |-> ($past(st_q.s2) == st_q.lvl));
endmodule

// File: rtl/susp_seq.sv
// Phase sequencer: staged entry and staged release.
module susp_seq
    import susp_pkg::*;
#(
    parameter int STEP_GAP  = 4,
    parameter int WAKE_DLY  = 16,
    parameter int SHORT_REL = 1,
    parameter int LONG_REL  = 512
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   lvl_i,
    input  logic   lock_long_i,
    input  logic   hold_long_i,
    output logic   awake_o,
    output logic   wr_lock_o,
    output logic   out_hold_o,
    output logic   in_en_o,
    output phase_t phase_o
);
    localparam int SMAX = (STEP_GAP > WAKE_DLY) ? STEP_GAP : WAKE_DLY;
    localparam int SW   = $clog2(SMAX + 1);
    localparam int RW   = $clog2(LONG_REL + 1);
    localparam logic [SW-1:0] STEP_LAST  = SW'(STEP_GAP - 1);
    localparam logic [SW-1:0] WAKE_LAST  = SW'(WAKE_DLY - 1);
    localparam logic [RW-1:0] SHORT_LAST = RW'(SHORT_REL - 1);
    localparam logic [RW-1:0] LONG_LAST  = RW'(LONG_REL - 1);

    typedef struct packed {
        phase_t        phase;
        logic [SW-1:0] cnt;
        logic [RW-1:0] lk_cnt;
        logic [RW-1:0] hd_cnt;
        logic          lk_long;
        logic          hd_long;
        logic          awake;
        logic          lock;
        logic          hold;
        logic          in_en;
    } seq_t;

    seq_t st_d, st_q;
    logic [RW-1:0] lk_last, hd_last;

    always_comb begin
        st_d    = st_q;
        lk_last = st_q.lk_long ? LONG_LAST : SHORT_LAST;
        hd_last = st_q.hd_long ? LONG_LAST : SHORT_LAST;
        case (st_q.phase)
            PH_AWAKE: begin
                if (lvl_i) begin
                    st_d.phase = PH_ENTER;
                    st_d.awake = 1'b0;
                    st_d.lock  = 1'b1;
                    st_d.cnt   = '0;
                end
            end
            PH_ENTER: begin
                if (st_q.cnt == STEP_LAST) begin
                    st_d.cnt = '0;
                    if (!st_q.hold) begin
                        st_d.hold = 1'b1;
                    end else begin
                        st_d.in_en = 1'b0;
                        st_d.phase = PH_SUSP;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_SUSP: begin
                if (!lvl_i) begin
                    st_d.phase   = PH_WAKE;
                    st_d.in_en   = 1'b1;
                    st_d.cnt     = '0;
                    st_d.lk_cnt  = '0;
                    st_d.hd_cnt  = '0;
                    st_d.lk_long = lock_long_i;
                    st_d.hd_long = hold_long_i;
                end
            end
            default: begin
                if (lvl_i) begin
                    st_d.phase = PH_SUSP;
                    st_d.awake = 1'b0;
                    st_d.lock  = 1'b1;
                    st_d.hold  = 1'b1;
                    st_d.in_en = 1'b0;
                end else if (!st_q.awake) begin
                    if (st_q.cnt == WAKE_LAST) st_d.awake = 1'b1;
                    else                       st_d.cnt   = st_q.cnt + 1'b1;
                end else begin
                    if (st_q.lock) begin
                        if (st_q.lk_cnt == lk_last) st_d.lock   = 1'b0;
                        else                        st_d.lk_cnt = st_q.lk_cnt + 1'b1;
                    end
                    if (st_q.hold) begin
                        if (st_q.hd_cnt == hd_last) st_d.hold   = 1'b0;
                        else                        st_d.hd_cnt = st_q.hd_cnt + 1'b1;
                    end
                    if (!st_d.lock && !st_d.hold) st_d.phase = PH_AWAKE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_AWAKE;
            st_q.awake <= 1'b1;
            st_q.in_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign awake_o    = st_q.awake;
    assign wr_lock_o  = st_q.lock;
    assign out_hold_o = st_q.hold;
    assign in_en_o    = st_q.in_en;
    assign phase_o    = st_q.phase;

    // R9
    in_off_protected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_en_o |-> (wr_lock_o && out_hold_o));
    // R9
    awake_needs_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        awake_o |-> in_en_o);
    // R1
    awake_phase_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_AWAKE) |-> (awake_o && !wr_lock_o && !out_hold_o && in_en_o));
    // R3
    sleep_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(awake_o) |-> wr_lock_o);
    // R4
    susp_inputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_SUSP) |-> !in_en_o);
endmodule

// File: rtl/susp_wake_seq.sv
module susp_wake_seq
    import susp_pkg::*;
#(
    parameter bit FILT_EN   = 1'b1,
    parameter int FILT_LEN  = 8,
    parameter int STEP_GAP  = 4,
    parameter int WAKE_DLY  = 16,
    parameter int SHORT_REL = 1,
    parameter int LONG_REL  = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       susp_req_i,
    input  logic       lock_long_i,
    input  logic       hold_long_i,
    output logic       awake_o,
    output logic       wr_lock_o,
    output logic       out_hold_o,
    output logic       in_en_o,
    output logic [1:0] phase_o
);
    logic   lvl;
    phase_t ph;

    susp_in_cond #(.FILT_EN(FILT_EN), .FILT_LEN(FILT_LEN)) cond_i (
        .clk(clk), .rst_n(rst_n), .req_i(susp_req_i), .lvl_o(lvl)
    );

    susp_seq #(.STEP_GAP(STEP_GAP), .WAKE_DLY(WAKE_DLY),
               .SHORT_REL(SHORT_REL), .LONG_REL(LONG_REL)) seq_i (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl),
        .lock_long_i(lock_long_i), .hold_long_i(hold_long_i),
        .awake_o(awake_o), .wr_lock_o(wr_lock_o), .out_hold_o(out_hold_o),
        .in_en_o(in_en_o), .phase_o(ph)
    );

    assign phase_o = ph;
endmodule

// File: tb/susp_wake_seq_tb_top.sv
module susp_wake_seq_tb_top;
    localparam int F = 4, G = 3, W = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic susp = 1'b0, lk_long = 1'b0, hd_long = 1'b0;
    logic awk, lck, hld, ien, awk_n, lck_n, hld_n, ien_n;
    logic [1:0] ph, ph_n;
    int cyc = 0, runs = 0, fails = 0;
    bit done = 0;
    int t_awf, t_awr, t_lkr, t_lkf, t_hdr, t_hdf, t_inf, t_inr, t_ps, t_pa, t_nf;
    logic p_awk = 1, p_lck = 0, p_hld = 0, p_ien = 1, p_nf = 1;
    logic [1:0] p_ph = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    susp_wake_seq #(.FILT_EN(1'b1), .FILT_LEN(F), .STEP_GAP(G), .WAKE_DLY(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .susp_req_i(susp), .lock_long_i(lk_long),
        .hold_long_i(hd_long), .awake_o(awk), .wr_lock_o(lck), .out_hold_o(hld),
        .in_en_o(ien), .phase_o(ph));

    susp_wake_seq #(.FILT_EN(1'b0), .FILT_LEN(F), .STEP_GAP(G), .WAKE_DLY(W)) dut_nf_i (
        .clk(clk), .rst_n(rst_n), .susp_req_i(susp), .lock_long_i(lk_long),
        .hold_long_i(hd_long), .awake_o(awk_n), .wr_lock_o(lck_n), .out_hold_o(hld_n),
        .in_en_o(ien_n), .phase_o(ph_n));

    // Record the edge number at which each output last changed.
    always @(negedge clk) if (rst_n) begin
        if (p_awk && !awk) t_awf = cyc;
        if (!p_awk && awk) t_awr = cyc;
        if (!p_lck && lck) t_lkr = cyc;
        if (p_lck && !lck) t_lkf = cyc;
        if (!p_hld && hld) t_hdr = cyc;
        if (p_hld && !hld) t_hdf = cyc;
        if (p_ien && !ien) t_inf = cyc;
        if (!p_ien && ien) t_inr = cyc;
        if (p_ph != ph && ph == 2'b10) t_ps = cyc;
        if (p_ph != ph && ph == 2'b00) t_pa = cyc;
        if (p_nf && !awk_n) t_nf = cyc;
        p_awk = awk; p_lck = lck; p_hld = hld; p_ien = ien; p_ph = ph; p_nf = awk_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        runs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Full entry then full exit with the given release selects.
    task automatic round(input bit gl, input bit hl);
        int c0, c1, e, a, nl, nh;
        @(negedge clk); lk_long = gl; hd_long = hl; susp = 1'b1; c0 = cyc;
        idle(40);
        e = c0 + 3 + F;
        eq("R3 awake fall", t_awf, e);
        eq("R3 lock rise", t_lkr, e);
        eq("R3 unfiltered awake fall", t_nf, c0 + 3);
        eq("R4 hold rise", t_hdr, e + G);
        eq("R4 input disable", t_inf, e + 2 * G);
        eq("R4 phase suspended", t_ps, e + 2 * G);
        susp = 1'b0; c1 = cyc;
        idle(560);
        a  = c1 + 3 + F + W;
        nl = gl ? 512 : 1;
        nh = hl ? 512 : 1;
        eq("R5 input enable", t_inr, c1 + 3 + F);
        eq("R5 awake rise", t_awr, a);
        eq("R6 lock release", t_lkf, a + nl);
        eq("R7 hold release", t_hdf, a + nh);
        eq("R7 phase awake", t_pa, a + ((nl > nh) ? nl : nh));
        eq("R7 final phase", int'(ph), 0);
    endtask

    initial begin
        int c;
        idle(3);
        eq("R1 awake", int'(awk), 1);
        eq("R1 lock", int'(lck), 0);
        eq("R1 hold", int'(hld), 0);
        eq("R1 inputs", int'(ien), 1);
        eq("R1 phase", int'(ph), 0);
        rst_n = 1'b1;
        idle(5);
        for (int i = 0; i < 4; i++) round(i[0], i[1]);

        // R2: a 3-cycle pulse is rejected, a 4-cycle pulse is accepted
        susp = 1'b1; idle(F - 1); susp = 1'b0;
        idle(30);
        eq("R2 short pulse awake", int'(awk), 1);
        eq("R2 short pulse phase", int'(ph), 0);
        susp = 1'b1; c = cyc; idle(F); susp = 1'b0;
        idle(40);
        eq("R2 long pulse accepted", t_awf, c + 3 + F);
        eq("R4 entry completes", t_inf, c + 3 + F + 2 * G);
        idle(30);

        // R8: a new suspend during the wake, with both releases pending
        lk_long = 1'b1; hd_long = 1'b1;
        susp = 1'b1; idle(40); susp = 1'b0; c = cyc;
        idle(3 + F + W + 10);
        eq("R8 awake before retrigger", int'(awk), 1);
        susp = 1'b1; c = cyc;
        idle(30);
        eq("R8 awake fall", t_awf, c + 3 + F);
        eq("R8 inputs off", t_inf, c + 3 + F);
        eq("R8 phase suspended", t_ps, c + 3 + F);
        eq("R8 lock held", int'(lck), 1);
        eq("R8 hold held", int'(hld), 1);
        eq("R8 phase now", int'(ph), 2);
        susp = 1'b0;
        idle(560);
        eq("R8 recovered", int'(ph), 0);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            runs++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end
endmodule